// File: doc/BRIEF.md
# Synchronous PWM gate sequencer

This block is the digital control for one current-mode PWM channel that drives a complementary pair of gates: a main switch gate and a synchronous-rectifier gate. A narrow clock pulse from the oscillator starts each switching period by setting a reset-dominant latch. Any trip flag that is present clears the latch: the ramp-versus-feedback comparator, the first current-limit comparator or the second current-limit comparator. The second current-limit trip also starts a blanking counter that keeps the main gate off for the next two clock pulses.

The latch output is a request, not a gate. A break-before-make stage turns the request into the two gate outputs. A gate may rise only after the opposite gate has been low for a programmable number of system clock cycles. The nominal dead time of 45 ns (allowed range 20 to 70 ns) is therefore set as a cycle count on `dt_cycles`. While `run` is low, both gates are held low and clock pulses have no effect.

Top module: `pwm_gate_seq`

## Requirements
- R1: A `clk_pulse` sampled with no trip present sets the request. The main gate then rises once the dead time has elapsed and stays high until a trip or `run` going low.
- R2: A `ramp_trip` or `ilim1_trip` clears the request. The main gate falls one cycle after the request clears, and the synchronous gate rises after the dead time.
- R3: An `ilim2_trip` clears the request and loads a blanking count of 2. Each later `clk_pulse` lowers the count by one. A pulse that arrives while the count is nonzero does not set the request, so the third pulse after the trip is the first that turns the main gate on.
- R4: An `ilim2_trip` that occurs while the blanking count is nonzero reloads the count to 2.
- R5: The main gate rises exactly D cycles after the synchronous gate falls, where D is the effective dead time.
- R6: The synchronous gate rises exactly D cycles after the main gate falls.
- R7: A `dt_cycles` value of 0 behaves as 1. For any other value, D equals `dt_cycles`.
- R8: While `run` is low, both gates are low from the next cycle on. A `clk_pulse` during that time leaves both gates low.
- R9: A trip that is present in the same cycle as `clk_pulse` wins: the request stays clear and the main gate does not rise.
- R10: Once the request has cleared, the main gate stays low until the next `clk_pulse`, even after the trip flags drop.
- R11: The main gate and the synchronous gate are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel enable; low forces both gates low |
| clk_pulse | input | 1 | Period-start pulse from the oscillator |
| ramp_trip | input | 1 | Ramp-versus-feedback comparator flag |
| ilim1_trip | input | 1 | First-level current-limit flag |
| ilim2_trip | input | 1 | Second-level current-limit flag (starts blanking) |
| dt_cycles | input | DT_W | Dead time in system clock cycles (0 treated as 1) |
| gate_main | output | 1 | Main switch gate |
| gate_sync | output | 1 | Synchronous-rectifier gate |

## Verification
The request register updates on the edge that samples a pulse or a trip. When the synchronous gate was high, it falls one edge later, and the main gate follows D edges after that. A trip therefore shows up on `gate_main` at the second edge after it is sampled, and `gate_sync` rises D edges after that. The bench applies each input vector right after a falling clock edge and compares the outputs at the next falling edge. Each table row therefore holds the gate values after the single rising edge that consumed that row's inputs. The expected timelines were derived from these edge counts for D = 2 and D = 1.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
    localparam int NUM_GATES = 2;
    localparam int GATE_MAIN = 0;
    localparam int GATE_SYNC = 1;
endpackage

// File: rtl/pwm_low_timer.sv
// Counts the cycles a gate has spent low. The count saturates and is cleared while the gate is high.
module pwm_low_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_q,
    output logic [CNT_W-1:0] low_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (gate_q)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_MAX;
        else        cnt_q <= cnt_d;
    end

    assign low_cnt = cnt_q;
endmodule

// File: rtl/pwm_trip_latch.sv
// Reset-dominant PWM latch with blanking after a second-level current trip.
module pwm_trip_latch #(
    parameter int BLANK_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clk_pulse,
    input  logic ramp_trip,
    input  logic ilim1_trip,
    input  logic ilim2_trip,
    output logic pwm_req
);
    localparam int SKIP_W = $clog2(BLANK_PULSES + 1);
    localparam logic [SKIP_W-1:0] SKIP_LOAD = SKIP_W'(BLANK_PULSES);

    typedef struct packed {
        logic              req;
        logic [SKIP_W-1:0] skip;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      clear_now;

    always_comb begin
        st_d      = st_q;
        clear_now = ramp_trip | ilim1_trip | ilim2_trip | (st_q.skip != '0);
        if (!run) begin
            st_d = '0;
        end else begin
            if (ilim2_trip)
                st_d.skip = SKIP_LOAD;
            else if (clk_pulse && st_q.skip != '0)
                st_d.skip = st_q.skip - 1'b1;
            if (clear_now)
                st_d.req = 1'b0;
            else if (clk_pulse)
                st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_req = st_q.req;

    // R1 / R10: the request only sets on an edge that sampled a clock pulse
    assert_set_needs_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $past(clk_pulse));
    // R3: the request is clear whenever blanking is active
    assert_blank_holds_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.skip != '0) |-> !st_q.req);
    // R9: a trip that coincides with the pulse wins
    assert_trip_beats_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clk_pulse && (ramp_trip || ilim1_trip)) |-> !st_q.req);
    // R4: the second-level trip always leaves a full blanking count
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && ilim2_trip) |-> (st_q.skip == SKIP_LOAD));
endmodule

// File: rtl/pwm_deadtime.sv
// Break-before-make stage: turns the request into two gates with dead time in both directions.
module pwm_deadtime
    import pwm_seq_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pwm_req,
    input  logic [DT_W-1:0] dt_cycles,
    output logic            gate_main,
    output logic            gate_sync
);
    localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

    logic [NUM_GATES-1:0] gate_d, gate_q, want;
    logic [DT_W-1:0]      low_cnt [NUM_GATES];
    logic [DT_W-1:0]      dt_eff, dt_thresh;

    assign dt_eff    = (dt_cycles == '0) ? DT_ONE : dt_cycles;
    assign dt_thresh = dt_eff - DT_ONE;

    assign want[GATE_MAIN] = run &  pwm_req;
    assign want[GATE_SYNC] = run & ~pwm_req;

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_side
        pwm_low_timer #(.CNT_W(DT_W)) u_low (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_q  (gate_q[g]),
            .low_cnt (low_cnt[g])
        );
    end

    always_comb begin
        for (int g = 0; g < NUM_GATES; g++) begin
            gate_d[g] = want[g] &&
                        (gate_q[g] ||
                         (!gate_q[NUM_GATES-1-g] && low_cnt[NUM_GATES-1-g] >= dt_thresh));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign gate_main = gate_q[GATE_MAIN];
    assign gate_sync = gate_q[GATE_SYNC];

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q[GATE_MAIN] && gate_q[GATE_SYNC]));
    // R5: the main gate rises only once the sync gate has been low long enough
    assert_main_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q[GATE_MAIN]) |-> ($past(low_cnt[GATE_SYNC]) >= $past(dt_thresh)));
    // R6: the sync gate rises only once the main gate has been low long enough
    assert_sync_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q[GATE_SYNC]) |-> ($past(low_cnt[GATE_MAIN]) >= $past(dt_thresh)));
endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
    parameter int DT_W         = 8,
    parameter int BLANK_PULSES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clk_pulse,
    input  logic            ramp_trip,
    input  logic            ilim1_trip,
    input  logic            ilim2_trip,
    input  logic [DT_W-1:0] dt_cycles,
    output logic            gate_main,
    output logic            gate_sync
);
    logic req;

    pwm_trip_latch #(.BLANK_PULSES(BLANK_PULSES)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .clk_pulse  (clk_pulse),
        .ramp_trip  (ramp_trip),
        .ilim1_trip (ilim1_trip),
        .ilim2_trip (ilim2_trip),
        .pwm_req    (req)
    );

    pwm_deadtime #(.DT_W(DT_W)) u_dead (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .pwm_req   (req),
        .dt_cycles (dt_cycles),
        .gate_main (gate_main),
        .gate_sync (gate_sync)
    );

    assert_run_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (!gate_main && !gate_sync));
endmodule

// File: tb/sim_pwm_gate_seq.sv
`timescale 1ns/1ps
module sim_pwm_gate_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, clk_pulse = 1'b0, ramp_trip = 1'b0, ilim1_trip = 1'b0, ilim2_trip = 1'b0;
    logic [7:0] dt_cycles = 8'd2;
    logic       gate_main, gate_sync;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    pwm_gate_seq u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_pulse(clk_pulse),
        .ramp_trip(ramp_trip), .ilim1_trip(ilim1_trip), .ilim2_trip(ilim2_trip),
        .dt_cycles(dt_cycles), .gate_main(gate_main), .gate_sync(gate_sync)
    );

    // Row fields: {run, pulse, ramp, ilim1, ilim2, expected main, expected sync}, dead time 2
    localparam logic [6:0] VEC [32] = '{
        7'b1000001, 7'b1100001, 7'b1000000, 7'b1000000, 7'b1000010, 7'b1000010,
        7'b1010010, 7'b1000000, 7'b1000000, 7'b1000001,
        7'b1101001, 7'b1000001,
        7'b1100001, 7'b1000000, 7'b1000000, 7'b1000010,
        7'b1000110, 7'b1000000, 7'b1000000, 7'b1000001,
        7'b1100001, 7'b1000001, 7'b1100001, 7'b1000001,
        7'b1100001, 7'b1000000, 7'b1000000, 7'b1000010,
        7'b0000000, 7'b0100000, 7'b1000001, 7'b1000001
    };

    function automatic string row_tag(int r);
        if (r < 6)  return "R1";
        if (r < 10) return "R2/R6";
        if (r < 12) return "R9";
        if (r < 16) return "R5";
        if (r < 28) return "R3";
        return "R8";
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a falling edge: drive, pass one rising edge, return at the next falling edge.
    task automatic step(logic [4:0] in);
        {run, clk_pulse, ramp_trip, ilim1_trip, ilim2_trip} = in;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("reset main R8", gate_main, 1'b0);
        check("reset sync R8", gate_sync, 1'b0);
        rst_n = 1'b1;

        for (int r = 0; r < 32; r++) begin
            step(VEC[r][6:2]);
            check({row_tag(r), " main"}, gate_main, VEC[r][1]);
            check({row_tag(r), " sync"}, gate_sync, VEC[r][0]);
        end

        // R7: a dead time of 0 acts as one cycle in both directions
        dt_cycles = 8'd0;
        step(5'b11000); check("R7 pulse main", gate_main, 1'b0);
        step(5'b10000); check("R7 sync off", gate_sync, 1'b0);
        step(5'b10000); check("R7 main on after 1", gate_main, 1'b1);
        step(5'b10100); check("R7 still on", gate_main, 1'b1);
        step(5'b10000); check("R7 main off", gate_main, 1'b0);
                        check("R7 sync waits", gate_sync, 1'b0);
        step(5'b10000); check("R7 sync on after 1", gate_sync, 1'b1);

        // R4: a second-level trip during blanking reloads the count
        dt_cycles = 8'd2;
        step(5'b10001);
        step(5'b11000);
        step(5'b10001);
        step(5'b11000); check("R4 blank 1", gate_main, 1'b0);
        step(5'b11000); check("R4 blank 2", gate_main, 1'b0);
        step(5'b10000);
        step(5'b10000);
        step(5'b10000); check("R4 still blank", gate_main, 1'b0);
                        check("R4 sync held", gate_sync, 1'b1);
        step(5'b11000);
        step(5'b10000);
        step(5'b10000);
        step(5'b10000); check("R4 turn-on after blanking", gate_main, 1'b1);

        // R10: a trip ends the period; releasing it without a pulse does not restart
        step(5'b10010);
        step(5'b10000);
        for (int k = 0; k < 5; k++) step(5'b10000);
        check("R10 no restart main", gate_main, 1'b0);
        check("R10 sync on", gate_sync, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule